// File: doc/BRIEF.md
# Register Instruction Broadcast Dispatcher

This block pulls 64-bit register instructions, one word at a time, from a host-fed valid/ready stream (the stand-in for a host-to-device DMA queue). It splits each word into an operation, a register address and write data, and drives the result onto one instruction bus that every attached register-owning client sees at the same moment. Each client watches the address and responds only when the address is one of its own registers. Clients that do not own the address stay silent.

Only one instruction is ever outstanding. The dispatcher holds the bus steady until the owning client pulses its done line. On a read, the OR of all clients' read-data outputs is captured and offered on a response stream. A write completes without any response word. If no client answers within 256 cycles, the instruction is discarded and a sticky error flag is raised. The dispatcher then goes back to the input stream. A long run of writes therefore drains at the pace the clients complete them, and the host waits for no reply per write.

Top module: `regbcast_dispatcher`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `bus_valid`, `rsp_valid` and `err_timeout` are 0.
- R2: An accepted word is decoded as follows. Bit 63 is the operation (1 = read, 0 = write), bits 47:32 are the address and bits 31:0 are the write data. Bits 62:48 have no effect on the bus.
- R3: From the cycle after acceptance, `bus_valid` is 1 and the decoded operation, address and data are shared by all clients. They stay unchanged until completion or timeout.
- R4: While an instruction is on the bus, or its read response is waiting, `in_ready` is 0 and no further word is taken.
- R5: Completion is the OR of all client done bits, so any single client's done pulse ends the instruction.
- R6: When a read completes, the OR of all clients' read-data slices appears on `rsp_data` with `rsp_valid` = 1 in the next cycle. It is held stable until `rsp_ready` is 1.
- R7: When a write completes, no response word is produced, and `in_ready` returns to 1 in the next cycle.
- R8: If no done bit is seen during 256 consecutive bus cycles, `bus_valid` drops after exactly 256 cycles, the instruction is discarded and `err_timeout` becomes 1. It stays 1 until reset.
- R9: Back-to-back writes whose owner answers in the first bus cycle sustain one instruction every 2 clock cycles.
- R10: Reset during an outstanding instruction drops `bus_valid` and clears `err_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word available |
| in_ready | output | 1 | Dispatcher will take a word |
| in_word | input | 64 | Instruction word |
| bus_valid | output | 1 | Instruction presented to clients |
| bus_rd | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 32 | Write data |
| cl_done | input | N_CL | One done bit per client |
| cl_rdata | input | N_CL*32 | Read data per client, packed |
| rsp_valid | output | 1 | Read response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read response data |
| err_timeout | output | 1 | Sticky unclaimed-instruction flag |

## Verification
The assertions assume that clients raise done only while `bus_valid` is high. They also assume that at most the owning client drives nonzero read data in that cycle and that each done is a single-cycle pulse. The bench's client model follows these rules. It drives done and read data only for the owner, selected by address bits 15:14. It drives them only in a cycle where the bus is valid, and clears them again at the next falling edge. Addresses with bits 15:14 equal to 3 have no owner, and the bench uses them to force the timeout.

// File: rtl/regbcast_pkg.sv
package regbcast_pkg;
    localparam int WORD_W = 64;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int OP_BIT = 63;
    localparam int ADDR_LSB = 32;

    typedef enum logic {
        OP_WR = 1'b0,
        OP_RD = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    function automatic instr_t unpack_word(input logic [WORD_W-1:0] w);
        instr_t r;
        r.op   = op_e'(w[OP_BIT]);
        r.addr = w[ADDR_LSB +: ADDR_W];
        r.data = w[DATA_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/regbcast_decode.sv
module regbcast_decode
    import regbcast_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output instr_t            instr
);
    always_comb instr = unpack_word(word);
endmodule

// File: rtl/regbcast_merge.sv
module regbcast_merge
    import regbcast_pkg::*;
#(
    parameter int N_CL = 4
) (
    input  logic [N_CL-1:0]        done_vec,
    input  logic [N_CL*DATA_W-1:0] rdata_vec,
    output logic                   any_done,
    output logic [DATA_W-1:0]      rdata_or
);
    logic [DATA_W-1:0] acc [N_CL+1];

    assign acc[0] = '0;
    for (genvar k = 0; k < N_CL; k++) begin : g_or
        assign acc[k+1] = acc[k] | rdata_vec[k*DATA_W +: DATA_W];
    end

    assign rdata_or = acc[N_CL];
    assign any_done = |done_vec;
endmodule

// File: rtl/regbcast_timer.sv
module regbcast_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || expire) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    assert_idle_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/regbcast_dispatcher.sv
module regbcast_dispatcher
    import regbcast_pkg::*;
#(
    parameter int N_CL    = 4,
    parameter int TIMEOUT = 256
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [63:0]            in_word,
    output logic                   bus_valid,
    output logic                   bus_rd,
    output logic [15:0]            bus_addr,
    output logic [31:0]            bus_wdata,
    input  logic [N_CL-1:0]        cl_done,
    input  logic [N_CL*32-1:0]     cl_rdata,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [31:0]            rsp_data,
    output logic                   err_timeout
);
    state_e            state;
    instr_t            cur;
    instr_t            dec;
    logic              any_done;
    logic [DATA_W-1:0] rd_or;
    logic [DATA_W-1:0] rsp_q;
    logic              err_q;
    logic              tmo;
    logic              take;

    regbcast_decode u_dec (
        .word  (in_word),
        .instr (dec)
    );

    regbcast_merge #(.N_CL(N_CL)) u_merge (
        .done_vec  (cl_done),
        .rdata_vec (cl_rdata),
        .any_done  (any_done),
        .rdata_or  (rd_or)
    );

    regbcast_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (bus_valid && !any_done),
        .expire (tmo)
    );

    assign in_ready = (state == ST_IDLE);
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
            rsp_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (take) begin
                    cur   <= dec;
                    state <= ST_ISSUE;
                end
                ST_ISSUE: if (any_done) begin
                    if (cur.op == OP_RD) begin
                        rsp_q <= rd_or;
                        state <= ST_RESP;
                    end else begin
                        state <= ST_IDLE;
                    end
                end else if (tmo) begin
                    err_q <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid   = (state == ST_ISSUE);
    assign bus_rd      = (cur.op == OP_RD);
    assign bus_addr    = cur.addr;
    assign bus_wdata   = cur.data;
    assign rsp_valid   = (state == ST_RESP);
    assign rsp_data    = rsp_q;
    assign err_timeout = err_q;

    assert_bus_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !any_done && !tmo) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_rd) && $stable(bus_wdata)));
    assert_single_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid || rsp_valid) |-> !in_ready);
    assert_rd_rsp_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_rd && any_done) |=> (rsp_valid && rsp_data == $past(rd_or)));
    assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
    assert_no_wr_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_rd && any_done) |=> (!rsp_valid && in_ready));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_timeout |=> err_timeout);
    assert_done_ends_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && any_done) |=> !bus_valid);
endmodule

// File: tb/regbcast_dispatcher_tb.sv
module regbcast_dispatcher_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_CL = 4;
    localparam int TMO = 256;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic [63:0]       in_word;
    logic              bus_valid;
    logic              bus_rd;
    logic [15:0]       bus_addr;
    logic [31:0]       bus_wdata;
    logic [N_CL-1:0]   cl_done;
    logic [N_CL*32-1:0] cl_rdata;
    logic              rsp_valid;
    logic              rsp_ready;
    logic [31:0]       rsp_data;
    logic              err_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [31:0] regs [64];

    regbcast_dispatcher #(.N_CL(N_CL), .TIMEOUT(TMO)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .bus_valid(bus_valid), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .cl_done(cl_done), .cl_rdata(cl_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .err_timeout(err_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cyc++;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0; in_word = '0; cl_done = '0; cl_rdata = '0; rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // One instruction: lat = extra bus cycles before the owner answers,
    // hold = cycles the response consumer stalls.
    task automatic do_instr(input logic rd, input logic [15:0] a, input logic [31:0] d,
                            input int lat, input int hold, input logic [14:0] junk);
        int owner;
        logic [31:0] expv;
        owner = int'(a[15:14]);
        while (!in_ready) @(negedge clk);
        in_word  = {rd, junk, a, d};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_valid == 1'b1, "R3 bus_valid after accept", bus_valid, 1);
        check(bus_rd == rd, "R2 op bit", bus_rd, rd);
        check(bus_addr == a, "R2 address", bus_addr, a);
        if (!rd) check(bus_wdata == d, "R2 write data", bus_wdata, d);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(bus_valid && bus_addr == a, "R3 bus held", bus_addr, a);
            check(in_ready == 1'b0, "R4 no accept in flight", in_ready, 0);
        end
        expv = regs[{a[15:14], a[3:0]}];
        cl_done[owner] = 1'b1;
        if (rd) cl_rdata[owner*32 +: 32] = expv;
        else    regs[{a[15:14], a[3:0]}] = bus_wdata;
        @(negedge clk);
        cl_done = '0;
        cl_rdata = '0;
        check(bus_valid == 1'b0, "R5 done ends issue", bus_valid, 0);
        if (rd) begin
            check(rsp_valid == 1'b1, "R6 rsp_valid", rsp_valid, 1);
            check(rsp_data == expv, "R6 rsp_data", rsp_data, expv);
            for (int i = 0; i < hold; i++) begin
                @(negedge clk);
                check(rsp_valid && rsp_data == expv, "R6 rsp held", rsp_data, expv);
                check(in_ready == 1'b0, "R4 blocked by pending rsp", in_ready, 0);
            end
            rsp_ready = 1'b1;
            @(negedge clk);
            rsp_ready = 1'b0;
            check(rsp_valid == 1'b0, "R6 rsp taken", rsp_valid, 0);
        end else begin
            check(rsp_valid == 1'b0, "R7 no write rsp", rsp_valid, 0);
            check(in_ready == 1'b1, "R7 ready after write", in_ready, 1);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        check(bus_valid == 1'b0, "R1 bus_valid", bus_valid, 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(err_timeout == 1'b0, "R1 err", err_timeout, 0);
    endtask

    task automatic t_write_read();
        do_instr(1'b0, 16'h0003, 32'hDEAD_BEEF, 0, 0, 15'h7FFF);
        do_instr(1'b0, 16'h4005, 32'h1234_5678, 3, 0, 15'h0);
        do_instr(1'b0, 16'h800A, 32'hA5A5_0F0F, 1, 0, 15'h2AAA);
        do_instr(1'b1, 16'h0003, 32'hFFFF_FFFF, 2, 0, 15'h5555);
        do_instr(1'b1, 16'h4005, 32'h0, 0, 4, 15'h0);
        do_instr(1'b1, 16'h800A, 32'h0, 5, 1, 15'h1);
    endtask

    task automatic t_hold_off();
        // R4: second word waits while first is in flight
        while (!in_ready) @(negedge clk);
        in_word = {1'b0, 15'h0, 16'h0007, 32'h0000_0011};
        in_valid = 1'b1;
        @(negedge clk);
        in_word = {1'b0, 15'h0, 16'h0008, 32'h0000_0022};
        repeat (3) @(negedge clk);
        check(bus_addr == 16'h0007, "R4 second word not taken", bus_addr, 16'h0007);
        cl_done[0] = 1'b1;
        @(negedge clk);
        cl_done = '0;
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_valid && bus_addr == 16'h0008, "R4 second word after done", bus_addr, 16'h0008);
        cl_done[0] = 1'b1;
        @(negedge clk);
        cl_done = '0;
    endtask

    task automatic t_burst();
        int start;
        @(negedge clk);
        start = cyc;
        for (int i = 0; i < 8; i++)
            do_instr(1'b0, 16'h4000 | 16'(i), 32'(i * 3 + 1), 0, 0, 15'h0);
        check(cyc - start == 16, "R9 burst cycles", cyc - start, 16);
        do_instr(1'b1, 16'h4006, 32'h0, 0, 0, 15'h0);
    endtask

    task automatic t_timeout();
        int cnt = 0;
        while (!in_ready) @(negedge clk);
        in_word = {1'b1, 15'h0, 16'hC005, 32'h0};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (bus_valid && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == TMO, "R8 timeout length", cnt, TMO);
        check(err_timeout == 1'b1, "R8 err raised", err_timeout, 1);
        check(rsp_valid == 1'b0, "R8 no rsp after drop", rsp_valid, 0);
        do_instr(1'b0, 16'h0001, 32'h77, 0, 0, 15'h0);
        check(err_timeout == 1'b1, "R8 err sticky", err_timeout, 1);
    endtask

    task automatic t_reset_mid();
        while (!in_ready) @(negedge clk);
        in_word = {1'b0, 15'h0, 16'h0002, 32'h5};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(bus_valid == 1'b1, "R10 in flight before reset", bus_valid, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(bus_valid == 1'b0, "R10 bus dropped", bus_valid, 0);
        check(err_timeout == 1'b0, "R10 err cleared", err_timeout, 0);
        check(in_ready == 1'b1, "R10 ready", in_ready, 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) regs[i] = 32'(i) ^ 32'hC0DE_0000;
        t_reset_state();
        t_write_read();
        t_hold_off();
        t_burst();
        t_timeout();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule